// File: doc/BRIEF.md
# Packed Floating-Point Class Tester

The block examines a 128-bit packed operand and decides, lane by lane, whether each IEEE-754 value belongs to any of the classes picked by a 7-bit selection mask. A size input chooses the layout. It is either four 32-bit single-precision lanes or two 64-bit double-precision lanes. Both layouts are examined by classifiers that run side by side, and the size input picks which set of results is kept. A lane that matches is written as all ones over its full width. A lane that does not match is written as all zeros.

An operand is accepted on any cycle where `in_valid` is high. The verdict is registered and appears one cycle later, with `out_valid` high for that single cycle. The registered result then stays unchanged until the next accepted operand. A small sequencer tracks the result register in three states. `ST_EMPTY` means nothing has been captured since reset. `ST_SHOW` means a fresh verdict is being presented. `ST_HOLD` means the last verdict is being held. The transitions are as follows:
- Any state moves to `ST_SHOW` on `in_valid`.
- `ST_SHOW` moves to `ST_HOLD` when no operand arrives.
- `ST_EMPTY` and `ST_HOLD` stay where they are when no operand arrives.
- Reset forces `ST_EMPTY`.

Top module: `vfp_class_tester`

## Requirements
- R1: Selection mask bits mean: bit 6 NaN of either sign, bit 5 +infinity, bit 4 -infinity, bit 3 +0, bit 2 -0, bit 1 +denormal, bit 0 -denormal.
- R2: An all-zero selection mask yields an all-zero 128-bit result for any operand.
- R3: `in_dp`=0 splits the operand into four 32-bit lanes (lane i at bits 32i+31:32i, sign bit 31, 8-bit exponent, 23-bit fraction). `in_dp`=1 splits it into two 64-bit lanes (sign bit 63, 11-bit exponent, 52-bit fraction).
- R4: A lane whose magnitude (sign cleared) is unsigned-greater than the all-ones-exponent pattern is a NaN. Quiet and signalling NaNs of both signs match bit 6.
- R5: A lane with an all-ones exponent and a zero fraction is an infinity. Its sign selects bit 5 or bit 4.
- R6: A lane with every non-sign bit zero is a zero. Its sign selects bit 3 or bit 2.
- R7: A lane with a zero exponent and a non-zero fraction is a denormal. Its sign selects bit 1 or bit 0. The largest denormal matches, and the smallest normal does not.
- R8: With several mask bits set, a lane matches when it falls into any one of the selected classes.
- R9: Finite normal non-zero lanes never match, whatever the mask.
- R10: A matching lane is all ones over its lane width: 32 bits for single precision, 64 bits for double precision. A non-matching lane is all zeros.
- R11: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and low otherwise.
- R12: The result holds its value until the next accepted operand. Inputs changed while `in_valid` is low have no effect on it.
- R13: Synchronous active-high reset clears `out_valid` and the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 128 | Packed operand |
| in_mask | input | 7 | Class selection mask |
| in_dp | input | 1 | Lane size: 0 = 4x32-bit, 1 = 2x64-bit |
| out_valid | output | 1 | Verdict valid, one cycle after the strobe |
| out_data | output | 128 | Per-lane all-ones / all-zeros verdict |

## Verification
The bench builds the block with its default parameters: a 128-bit operand with the 8/23 and 11/52 exponent/fraction layouts. At this size every one of the 128 selection masks can be swept at both lane sizes. Each mask is applied to fourteen operands, built by rotating a set of boundary lane patterns across the lanes. The patterns are signed zeros, the smallest and largest denormals, the smallest and largest normals, both infinities, and quiet, signalling and negative NaNs. As a result, every class meets every mask bit in every lane position. Directed cases add the strobe timing, the holding of the result, inputs that change without a strobe, and reset during operation.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

    localparam int CLS_W = 7;

    localparam int CB_NEG_DEN  = 0;
    localparam int CB_POS_DEN  = 1;
    localparam int CB_NEG_ZERO = 2;
    localparam int CB_POS_ZERO = 3;
    localparam int CB_NEG_INF  = 4;
    localparam int CB_POS_INF  = 5;
    localparam int CB_NAN      = 6;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_SHOW  = 2'd1,
        ST_HOLD  = 2'd2
    } vfc_state_e;

    typedef enum logic {
        SZ_SINGLE = 1'b0,
        SZ_DOUBLE = 1'b1
    } vfc_size_e;

    typedef struct packed {
        logic is_nan;
        logic is_inf;
        logic is_zero;
        logic is_den;
        logic neg;
    } vfc_class_t;

endpackage

// File: rtl/vfc_lane_classify.sv
module vfc_lane_classify
    import vfc_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] lane_i,
    input  logic [CLS_W-1:0]      sel_i,
    output logic                  hit_o
);

    localparam int LANE_W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              exp_none;
    logic              frac_none;
    vfc_class_t        cls;
    logic [CLS_W-1:0]  cls_vec;

    assign exp_f     = lane_i[LANE_W-2 -: EXP_W];
    assign frac_f    = lane_i[FRAC_W-1:0];
    assign exp_ones  = &exp_f;
    assign exp_none  = ~|exp_f;
    assign frac_none = ~|frac_f;

    always_comb begin
        cls.neg     = lane_i[LANE_W-1];
        cls.is_nan  = exp_ones & ~frac_none;
        cls.is_inf  = exp_ones &  frac_none;
        cls.is_zero = exp_none &  frac_none;
        cls.is_den  = exp_none & ~frac_none;
    end

    always_comb begin
        cls_vec              = '0;
        cls_vec[CB_NEG_DEN]  = cls.is_den  &  cls.neg;
        cls_vec[CB_POS_DEN]  = cls.is_den  & ~cls.neg;
        cls_vec[CB_NEG_ZERO] = cls.is_zero &  cls.neg;
        cls_vec[CB_POS_ZERO] = cls.is_zero & ~cls.neg;
        cls_vec[CB_NEG_INF]  = cls.is_inf  &  cls.neg;
        cls_vec[CB_POS_INF]  = cls.is_inf  & ~cls.neg;
        cls_vec[CB_NAN]      = cls.is_nan;
    end

    assign hit_o = |(cls_vec & sel_i);

endmodule

// File: rtl/vfc_lane_bank.sv
module vfc_lane_bank
    import vfc_pkg::*;
#(
    parameter int DATA_W = 128,
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CLS_W-1:0]  sel_i,
    output logic [DATA_W-1:0] wide_o
);

    localparam int LANE_W = 1 + EXP_W + FRAC_W;
    localparam int NLANES = DATA_W / LANE_W;

    logic [NLANES-1:0] hit;

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        vfc_lane_classify #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_cls (
            .lane_i (data_i[g*LANE_W +: LANE_W]),
            .sel_i  (sel_i),
            .hit_o  (hit[g])
        );
        assign wide_o[g*LANE_W +: LANE_W] = {LANE_W{hit[g]}};
    end

    if (NLANES * LANE_W < DATA_W) begin : g_pad
        assign wide_o[DATA_W-1:NLANES*LANE_W] = '0;
    end

endmodule

// File: rtl/vfc_seq.sv
module vfc_seq
    import vfc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic load_o,
    output logic show_o
);

    vfc_state_e state_q;
    vfc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = start_i ? ST_SHOW : ST_EMPTY;
            ST_SHOW:  state_d = start_i ? ST_SHOW : ST_HOLD;
            ST_HOLD:  state_d = start_i ? ST_SHOW : ST_HOLD;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load_o = start_i;
        show_o = (state_q == ST_SHOW);
    end

endmodule

// File: rtl/vfp_class_tester.sv
module vfp_class_tester
    import vfc_pkg::*;
#(
    parameter int DATA_W    = 128,
    parameter int SP_EXP_W  = 8,
    parameter int SP_FRAC_W = 23,
    parameter int DP_EXP_W  = 11,
    parameter int DP_FRAC_W = 52
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CLS_W-1:0]  in_mask,
    input  logic              in_dp,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic [DATA_W-1:0] sp_wide;
    logic [DATA_W-1:0] dp_wide;
    logic [DATA_W-1:0] res_d;
    logic [DATA_W-1:0] res_q;
    logic              load;
    logic              show;
    vfc_size_e         size_sel;

    assign size_sel = vfc_size_e'(in_dp);

    vfc_lane_bank #(
        .DATA_W (DATA_W),
        .EXP_W  (SP_EXP_W),
        .FRAC_W (SP_FRAC_W)
    ) u_sp_bank (
        .data_i (in_data),
        .sel_i  (in_mask),
        .wide_o (sp_wide)
    );

    vfc_lane_bank #(
        .DATA_W (DATA_W),
        .EXP_W  (DP_EXP_W),
        .FRAC_W (DP_FRAC_W)
    ) u_dp_bank (
        .data_i (in_data),
        .sel_i  (in_mask),
        .wide_o (dp_wide)
    );

    vfc_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (in_valid),
        .load_o  (load),
        .show_o  (show)
    );

    always_comb begin
        if (in_mask == '0) begin
            res_d = '0;
        end else if (size_sel == SZ_DOUBLE) begin
            res_d = dp_wide;
        end else begin
            res_d = sp_wide;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else if (load) begin
            res_q <= res_d;
        end
    end

    assign out_data  = res_q;
    assign out_valid = show;

endmodule

// File: rtl/vfp_class_tester_chk.sv
module vfp_class_tester_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [127:0] in_data,
    input logic [6:0]   in_mask,
    input logic         in_dp,
    input logic         out_valid,
    input logic [127:0] out_data
);

    p_lat_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_zero_mask_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid && (in_mask == 7'd0) |=> (out_data == 128'd0));

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));

    for (genvar g = 0; g < 4; g++) begin : g_sp
        p_sp_fill_r10: assert property (@(posedge clk) disable iff (rst)
            in_valid && !in_dp |=>
                (out_data[g*32 +: 32] == 32'd0) || (out_data[g*32 +: 32] == 32'hFFFF_FFFF));
    end

    for (genvar g = 0; g < 2; g++) begin : g_dp
        p_dp_fill_r10: assert property (@(posedge clk) disable iff (rst)
            in_valid && in_dp |=>
                (out_data[g*64 +: 64] == 64'd0) || (out_data[g*64 +: 64] == {64{1'b1}}));
    end

    p_normal_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_dp && (in_data[30:23] != 8'h00) && (in_data[30:23] != 8'hFF)
            |=> (out_data[31:0] == 32'd0));

    p_nan_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_dp && in_mask[6] && (in_data[30:0] > 31'h7F80_0000)
            |=> (out_data[31:0] == 32'hFFFF_FFFF));

endmodule

bind vfp_class_tester vfp_class_tester_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_mask   (in_mask),
    .in_dp     (in_dp),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/vfp_class_tester_bench.sv
module vfp_class_tester_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] in_data = '0;
    logic [6:0]   in_mask = '0;
    logic         in_dp = 1'b0;
    logic         out_valid;
    logic [127:0] out_data;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    vfp_class_tester u_vfp_class_tester (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_mask   (in_mask),
        .in_dp     (in_dp),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic logic [31:0] sp_pat(input int k);
        case (k)
            0:       return 32'h0000_0000;
            1:       return 32'h8000_0000;
            2:       return 32'h0000_0001;
            3:       return 32'h007F_FFFF;
            4:       return 32'h807F_FFFF;
            5:       return 32'h0080_0000;
            6:       return 32'h8080_0000;
            7:       return 32'h7F80_0000;
            8:       return 32'hFF80_0000;
            9:       return 32'h7FC0_0000;
            10:      return 32'h7F80_0001;
            11:      return 32'hFFC0_0000;
            12:      return 32'h3F80_0000;
            default: return 32'h7F7F_FFFF;
        endcase
    endfunction

    function automatic logic [63:0] dp_pat(input int k);
        case (k)
            0:       return 64'h0000_0000_0000_0000;
            1:       return 64'h8000_0000_0000_0000;
            2:       return 64'h0000_0000_0000_0001;
            3:       return 64'h000F_FFFF_FFFF_FFFF;
            4:       return 64'h800F_FFFF_FFFF_FFFF;
            5:       return 64'h0010_0000_0000_0000;
            6:       return 64'h8010_0000_0000_0000;
            7:       return 64'h7FF0_0000_0000_0000;
            8:       return 64'hFFF0_0000_0000_0000;
            9:       return 64'h7FF8_0000_0000_0000;
            10:      return 64'h7FF0_0000_0000_0001;
            11:      return 64'hFFF8_0000_0000_0000;
            12:      return 64'h3FF0_0000_0000_0000;
            default: return 64'h7FEF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    // Class decision by magnitude comparison against the infinity pattern
    // and the smallest normal.
    function automatic bit lane_hit(input logic [63:0] mag, input bit neg,
                                    input logic [63:0] inf_pat, input logic [63:0] min_norm,
                                    input logic [6:0] m);
        bit isnan, isinf, iszero, isden;
        isnan  = mag > inf_pat;
        isinf  = mag == inf_pat;
        iszero = mag == 64'd0;
        isden  = (mag != 64'd0) && (mag < min_norm);
        return (m[6] && isnan) || (m[5] && isinf && !neg) || (m[4] && isinf && neg) ||
               (m[3] && iszero && !neg) || (m[2] && iszero && neg) ||
               (m[1] && isden && !neg) || (m[0] && isden && neg);
    endfunction

    function automatic logic [127:0] model(input logic [127:0] op, input logic [6:0] m,
                                           input bit dp);
        logic [127:0] r;
        r = '0;
        if (!dp) begin
            for (int i = 0; i < 4; i++) begin
                logic [31:0] v;
                v = op[i*32 +: 32];
                if (lane_hit({33'd0, v[30:0]}, v[31], 64'h7F80_0000, 64'h0080_0000, m))
                    r[i*32 +: 32] = '1;
            end
        end else begin
            for (int i = 0; i < 2; i++) begin
                logic [63:0] v;
                v = op[i*64 +: 64];
                if (lane_hit({1'b0, v[62:0]}, v[63], 64'h7FF0_0000_0000_0000,
                             64'h0010_0000_0000_0000, m))
                    r[i*64 +: 64] = '1;
            end
        end
        return r;
    endfunction

    task automatic check128(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // Strobe one operand; returns at the negedge after the capturing edge.
    task automatic apply(input logic [127:0] op, input logic [6:0] m, input bit dp);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = op;
        in_mask  = m;
        in_dp    = dp;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic directed(input string tag, input logic [127:0] op, input logic [6:0] m,
                            input bit dp, input logic [127:0] exp);
        apply(op, m, dp);
        check128(tag, out_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL R11 watchdog: actual still running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        // R13 reset state
        check1("R13 reset out_valid", out_valid, 1'b0);
        check128("R13 reset result", out_data, '0);
        rst = 1'b0;
        @(negedge clk);
        check1("R11 idle out_valid", out_valid, 1'b0);

        // R11 one-cycle pulse
        apply({4{32'h7FC0_0000}}, 7'h40, 1'b0);
        check1("R11 valid after strobe", out_valid, 1'b1);
        check128("R4 NaN all lanes", out_data, {128{1'b1}});
        @(negedge clk);
        check1("R11 valid drops", out_valid, 1'b0);

        // R12 hold and input changes without strobe
        held = out_data;
        in_data = '0;
        in_mask = 7'h7F;
        in_dp   = 1'b1;
        repeat (3) @(negedge clk);
        check128("R12 held with idle inputs", out_data, held);
        check1("R12 no valid without strobe", out_valid, 1'b0);

        // Directed classes
        directed("R2 zero mask", {128{1'b1}}, 7'h00, 1'b0, '0);
        directed("R2 zero mask dp", 128'd0, 7'h00, 1'b1, '0);
        directed("R4 sp qNaN sNaN -qNaN",
                 {32'h7F80_0000, 32'hFFC0_0000, 32'h7F80_0001, 32'h7FC0_0000}, 7'h40, 1'b0,
                 {32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF});
        directed("R4 dp -qNaN sNaN",
                 {64'hFFF8_0000_0000_0000, 64'h7FF0_0000_0000_0001}, 7'h40, 1'b1,
                 {128{1'b1}});
        directed("R5 sp +inf only",
                 {32'hFF80_0000, 32'h7F80_0000, 32'h7F7F_FFFF, 32'h7FC0_0000}, 7'h20, 1'b0,
                 {32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0});
        directed("R5 dp -inf only",
                 {64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000}, 7'h10, 1'b1,
                 {{64{1'b1}}, 64'h0});
        directed("R6 dp -0 only",
                 {64'h8000_0000_0000_0000, 64'h0}, 7'h04, 1'b1, {{64{1'b1}}, 64'h0});
        directed("R7 sp +denormal vs smallest normal",
                 {32'h807F_FFFF, 32'h007F_FFFF, 32'h0080_0000, 32'h0000_0001}, 7'h02, 1'b0,
                 {32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF});
        directed("R7 dp -largest denormal vs smallest normal",
                 {64'h800F_FFFF_FFFF_FFFF, 64'h0010_0000_0000_0000}, 7'h01, 1'b1,
                 {{64{1'b1}}, 64'h0});
        directed("R8 mask union",
                 {32'h7FC0_0000, 32'h8000_0000, 32'h0000_0001, 32'h3F80_0000}, 7'h45, 1'b0,
                 {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0});
        directed("R9 normals all masks",
                 {32'h3F80_0000, 32'h7F7F_FFFF, 32'h8080_0000, 32'h0080_0000}, 7'h7F, 1'b0,
                 '0);
        directed("R9 dp normals all masks",
                 {64'h7FEF_FFFF_FFFF_FFFF, 64'h8010_0000_0000_0000}, 7'h7F, 1'b1, '0);
        directed("R10 dp full-width fill",
                 {64'h7FF0_0000_0000_0000, 64'h0}, 7'h28, 1'b1, {128{1'b1}});
        directed("R3 sp layout",
                 {64'h0, 32'h7F80_0000, 32'h0}, 7'h08, 1'b0,
                 {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF});
        directed("R3 dp layout",
                 {64'h0, 32'h7F80_0000, 32'h0}, 7'h08, 1'b1, {{64{1'b1}}, 64'h0});

        // R1 sweep: every mask, both sizes, rotated boundary patterns
        for (int dp = 0; dp < 2; dp++) begin
            for (int k = 0; k < 14; k++) begin
                logic [127:0] op;
                op = '0;
                if (dp == 0) begin
                    for (int i = 0; i < 4; i++) op[i*32 +: 32] = sp_pat((k + i) % 14);
                end else begin
                    for (int i = 0; i < 2; i++) op[i*64 +: 64] = dp_pat((k + i) % 14);
                end
                for (int m = 0; m < 128; m++) begin
                    apply(op, 7'(m), dp[0]);
                    check128((m == 0) ? "R2 sweep" : "R1 sweep", out_data,
                             model(op, 7'(m), dp[0]));
                end
            end
        end

        // R13 reset during operation
        apply({128{1'b1}}, 7'h40, 1'b0);
        @(negedge clk);
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check1("R13 reset clears valid", out_valid, 1'b0);
        check128("R13 reset clears result", out_data, '0);
        rst = 1'b0;
        @(negedge clk);
        check1("R13 stays idle after reset", out_valid, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule